// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how each of the five pipeline registers of an in-order processor (fetch, decode, execute, memory, write-back) updates at the next rising clock edge. It looks at the instruction codes sitting in the decode, execute and memory stages, at the two source register IDs in decode, at the memory destination of the execute-stage instruction and at the execute-stage branch outcome. From these it produces one stall and one bubble signal per register. Three hazards are resolved together: a value loaded from memory that is needed at once, a conditional jump that was wrongly predicted as taken, and a return whose target is not yet known.

The decision logic is purely combinational. The block also carries one parameterised pipeline register per stage, driven by those stall and bubble signals. Each register holds a tag that travels down the pipe. This lets the effect of every control setting be observed at the ports. A stalled register keeps its tag, a bubbled one takes the no-op tag 0, and a normal one loads its input.

Top module: `hz_ctrl_unit`

## Requirements
- R1: A load/use hazard exists when the execute-stage code is a load (5) or a pop (11), its memory destination is not 8 and it equals the decode-stage source A or source B. In that case stall bit 0 (F) and bit 1 (D) are 1 and bubble bit 2 (E) is 1. Bit order for both vectors is F=0, D=1, E=2, M=3, W=4.
- R2: Register ID 8 means "no register". A load or pop whose destination is 8 never causes a stall, even when a source ID is also 8.
- R3: When the execute-stage code is a jump (7) and the taken flag is 0, bubble D and E, and stall nothing. A taken jump causes no action.
- R4: While the return code (9) is in decode, execute or memory, stall F and bubble D.
- R5: When a load/use hazard and a pending return occur together, D is stalled, not bubbled. F is stalled and E is bubbled.
- R6: A not-taken jump in execute with a return in decode bubbles D and E and stalls F.
- R7: No stage ever has stall and bubble set at once. The M and W stages always update normally.
- R8: Each stage register loads its input in normal mode, keeps its value in stall mode and loads tag 0 in bubble mode, at the rising clock edge.
- R9: While rst_n is low, every stage register holds tag 0.
- R10: With no hazard present, all stall and bubble bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_icode | input | OPC_W (4) | Instruction code in decode |
| e_icode | input | OPC_W (4) | Instruction code in execute |
| m_icode | input | OPC_W (4) | Instruction code in memory |
| e_dst_mem | input | REG_W (4) | Memory destination register of execute-stage instruction |
| d_src_a | input | REG_W (4) | Decode-stage source register A |
| d_src_b | input | REG_W (4) | Decode-stage source register B |
| e_taken | input | 1 | Branch condition of execute-stage jump |
| stage_in | input | 5*TAG_W (40) | Next tag for each stage register, stage k in bits k*TAG_W upward |
| stall | output | 5 | Stall per stage, F in bit 0 |
| bubble | output | 5 | Bubble per stage, F in bit 0 |
| stage_q | output | 5*TAG_W (40) | Current tag of each stage register |

## Verification
The bench builds the block with its default parameters: 4-bit codes, 4-bit register IDs and 8-bit tags. With these, the "no register" ID 8 and every hazard code can be driven directly. The 8-bit tags make a held value easy to tell apart from a freshly loaded one or from the no-op value. Directed cycles place each hazard alone and in its combinations. A long stretch of biased random codes then drives overlapping load/use, misprediction and return windows, and each cycle is checked against the bench's model of the stage registers.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int OPC_W = 4;
  parameter int REG_W = 4;
  parameter int NSTG  = 5;

  localparam logic [OPC_W-1:0] OP_LOAD = OPC_W'(5);
  localparam logic [OPC_W-1:0] OP_JUMP = OPC_W'(7);
  localparam logic [OPC_W-1:0] OP_RET  = OPC_W'(9);
  localparam logic [OPC_W-1:0] OP_POP  = OPC_W'(11);
  localparam logic [REG_W-1:0] REG_NONE = REG_W'(8);

  typedef enum int unsigned {
    STG_F = 0,
    STG_D = 1,
    STG_E = 2,
    STG_M = 3,
    STG_W = 4
  } stage_e;

  typedef struct packed {
    logic load_use;
    logic mispredict;
    logic ret_pending;
  } hazard_t;
endpackage

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
(
  input  logic [OPC_W-1:0] d_icode,
  input  logic [OPC_W-1:0] e_icode,
  input  logic [OPC_W-1:0] m_icode,
  input  logic [REG_W-1:0] e_dst_mem,
  input  logic [REG_W-1:0] d_src_a,
  input  logic [REG_W-1:0] d_src_b,
  input  logic             e_taken,
  output hazard_t          haz
);
  logic e_is_load;
  logic dst_valid;
  logic dst_match;

  always_comb begin
    e_is_load = (e_icode == OP_LOAD) || (e_icode == OP_POP);
    dst_valid = (e_dst_mem != REG_NONE);
    dst_match = (e_dst_mem == d_src_a) || (e_dst_mem == d_src_b);
    haz.load_use    = e_is_load && dst_valid && dst_match;
    haz.mispredict  = (e_icode == OP_JUMP) && !e_taken;
    haz.ret_pending = (d_icode == OP_RET) || (e_icode == OP_RET) ||
                      (m_icode == OP_RET);
  end
endmodule

// File: rtl/hz_resolve.sv
module hz_resolve
  import hz_pkg::*;
(
  input  hazard_t         haz,
  output logic [NSTG-1:0] stall,
  output logic [NSTG-1:0] bubble
);
  always_comb begin
    stall  = '0;
    bubble = '0;
    // fetch holds for a load that is consumed now or a return in flight
    stall[STG_F]  = haz.load_use || haz.ret_pending;
    // decode holds the consumer; the load/use case outranks the return bubble
    stall[STG_D]  = haz.load_use;
    bubble[STG_D] = haz.mispredict || (haz.ret_pending && !haz.load_use);
    // execute gets a no-op behind a load or a cancelled path
    bubble[STG_E] = haz.mispredict || haz.load_use;
  end
endmodule

// File: rtl/hz_pipe_reg.sv
module hz_pipe_reg #(
  parameter int                 W       = 8,
  parameter logic [W-1:0]       NOP_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         en;
  logic [W-1:0] q_nxt;

  always_comb begin
    en    = bubble || !stall;
    q_nxt = bubble ? NOP_VAL : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= NOP_VAL;
    end else if (en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit
  import hz_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OPC_W-1:0]      d_icode,
  input  logic [OPC_W-1:0]      e_icode,
  input  logic [OPC_W-1:0]      m_icode,
  input  logic [REG_W-1:0]      e_dst_mem,
  input  logic [REG_W-1:0]      d_src_a,
  input  logic [REG_W-1:0]      d_src_b,
  input  logic                  e_taken,
  input  logic [NSTG*TAG_W-1:0] stage_in,
  output logic [NSTG-1:0]       stall,
  output logic [NSTG-1:0]       bubble,
  output logic [NSTG*TAG_W-1:0] stage_q
);
  hazard_t haz;

  hz_detect u_det (
    .d_icode   (d_icode),
    .e_icode   (e_icode),
    .m_icode   (m_icode),
    .e_dst_mem (e_dst_mem),
    .d_src_a   (d_src_a),
    .d_src_b   (d_src_b),
    .e_taken   (e_taken),
    .haz       (haz)
  );

  hz_resolve u_res (
    .haz    (haz),
    .stall  (stall),
    .bubble (bubble)
  );

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    hz_pipe_reg #(
      .W       (TAG_W),
      .NOP_VAL ('0)
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (stall[k]),
      .bubble (bubble[k]),
      .d      (stage_in[k*TAG_W +: TAG_W]),
      .q      (stage_q[k*TAG_W +: TAG_W])
    );
  end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
  import hz_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [OPC_W-1:0]      d_icode,
  input logic [OPC_W-1:0]      e_icode,
  input logic [OPC_W-1:0]      m_icode,
  input logic [REG_W-1:0]      e_dst_mem,
  input logic [REG_W-1:0]      d_src_a,
  input logic [REG_W-1:0]      d_src_b,
  input logic                  e_taken,
  input logic [NSTG-1:0]       stall,
  input logic [NSTG-1:0]       bubble,
  input logic [NSTG*TAG_W-1:0] stage_q
);
  assert_no_dual_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall & bubble) == '0);

  assert_tail_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall[4:3] == 2'b00 && bubble[4:3] == 2'b00);

  assert_load_use_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_icode == OP_LOAD || e_icode == OP_POP) && e_dst_mem != REG_NONE &&
     (e_dst_mem == d_src_a || e_dst_mem == d_src_b))
    |-> (stall[0] && stall[1] && bubble[2] && !bubble[1]));

  assert_none_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (e_dst_mem == REG_NONE && d_icode != OP_RET && m_icode != OP_RET &&
     e_icode != OP_JUMP && e_icode != OP_RET) |-> (stall == '0 && bubble == '0));

  assert_mispredict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_icode == OP_JUMP && !e_taken) |-> (bubble[1] && bubble[2] && !stall[1]));

  assert_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_icode == OP_RET || e_icode == OP_RET || m_icode == OP_RET) |-> stall[0]);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall[1] |=> $stable(stage_q[TAG_W +: TAG_W]));

  assert_nop_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bubble[2] |=> stage_q[2*TAG_W +: TAG_W] == '0);
endmodule

bind hz_ctrl_unit hz_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .d_icode   (d_icode),
  .e_icode   (e_icode),
  .m_icode   (m_icode),
  .e_dst_mem (e_dst_mem),
  .d_src_a   (d_src_a),
  .d_src_b   (d_src_b),
  .e_taken   (e_taken),
  .stall     (stall),
  .bubble    (bubble),
  .stage_q   (stage_q)
);

// File: tb/sim_hz_ctrl_unit.sv
`timescale 1ns/1ps
module sim_hz_ctrl_unit;
  localparam int TW = 8;
  localparam int NS = 5;

  logic            clk;
  logic            rst_n;
  logic [3:0]      d_icode, e_icode, m_icode;
  logic [3:0]      e_dst_mem, d_src_a, d_src_b;
  logic            e_taken;
  logic [NS*TW-1:0] stage_in;
  logic [NS-1:0]   stall, bubble;
  logic [NS*TW-1:0] stage_q;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  logic [TW-1:0] mq [NS];

  hz_ctrl_unit #(.TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .d_icode(d_icode), .e_icode(e_icode),
    .m_icode(m_icode), .e_dst_mem(e_dst_mem), .d_src_a(d_src_a),
    .d_src_b(d_src_b), .e_taken(e_taken), .stage_in(stage_in),
    .stall(stall), .bubble(bubble), .stage_q(stage_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference: mode per stage, 0 normal, 1 stall, 2 bubble
  function automatic void ref_modes(output int md [NS]);
    bit ld, mp, rt, lu;
    for (int k = 0; k < NS; k++) md[k] = 0;
    ld = (e_icode == 4'd5) || (e_icode == 4'd11);
    lu = ld && (e_dst_mem != 4'd8) && (e_dst_mem == d_src_a || e_dst_mem == d_src_b);
    mp = (e_icode == 4'd7) && (e_taken == 1'b0);
    rt = (d_icode == 4'd9) || (e_icode == 4'd9) || (m_icode == 4'd9);
    if (lu) begin
      md[0] = 1; md[1] = 1; md[2] = 2;
    end else if (mp) begin
      md[1] = 2; md[2] = 2;
      if (rt) md[0] = 1;
    end else if (rt) begin
      md[0] = 1; md[1] = 2;
    end
  endfunction

  function automatic logic [NS-1:0] exp_vec(input int want);
    int md [NS];
    logic [NS-1:0] v;
    ref_modes(md);
    for (int k = 0; k < NS; k++) v[k] = (md[k] == want);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) mq[k] <= '0;
    end else begin
      int md [NS];
      ref_modes(md);
      for (int k = 0; k < NS; k++) begin
        if (md[k] == 2) mq[k] <= '0;
        else if (md[k] == 0) mq[k] <= stage_in[k*TW +: TW];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_ctrl(input string tag);
    chk({tag, " stall"},  64'(stall),  64'(exp_vec(1)));
    chk({tag, " bubble"}, 64'(bubble), 64'(exp_vec(2)));
    chk("R7 dual", 64'(stall & bubble), 64'd0);
    chk("R7 tail", 64'({stall[4:3], bubble[4:3]}), 64'd0);
  endtask

  task automatic chk_regs(input string tag);
    for (int k = 0; k < NS; k++)
      chk(tag, 64'(stage_q[k*TW +: TW]), 64'(mq[k]));
  endtask

  task automatic drive(input logic [3:0] di, ei, mi, dst, sa, sb, input logic tk);
    d_icode = di; e_icode = ei; m_icode = mi;
    e_dst_mem = dst; d_src_a = sa; d_src_b = sb; e_taken = tk;
    for (int k = 0; k < NS; k++) stage_in[k*TW +: TW] = TW'($urandom_range(1, 255));
  endtask

  // one cycle: check registers from last edge, drive, check controls
  task automatic step(input string tag, input logic [3:0] di, ei, mi, dst, sa, sb,
                      input logic tk);
    @(negedge clk);
    chk_regs("R8 regs");
    drive(di, ei, mi, dst, sa, sb, tk);
    #1;
    chk_ctrl(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(4'd1, 4'd1, 4'd1, 4'd8, 4'd8, 4'd8, 1'b1);
    repeat (3) @(negedge clk);
    for (int k = 0; k < NS; k++) chk("R9 reset", 64'(stage_q[k*TW +: TW]), 64'd0);
    rst_n = 1'b1;

    step("R10 idle",   4'd1, 4'd1, 4'd1, 4'd8, 4'd0, 4'd3, 1'b1);
    step("R1 srcA",    4'd6, 4'd5, 4'd1, 4'd2, 4'd2, 4'd3, 1'b1);
    step("R1 srcB",    4'd6, 4'd5, 4'd1, 4'd3, 4'd2, 4'd3, 1'b1);
    step("R1 pop",     4'd6, 4'd11, 4'd1, 4'd4, 4'd4, 4'd8, 1'b0);
    step("R1 nomatch", 4'd6, 4'd5, 4'd1, 4'd4, 4'd1, 4'd2, 1'b0);
    step("R2 none",    4'd6, 4'd5, 4'd1, 4'd8, 4'd8, 4'd8, 1'b0);
    step("R2 popnone", 4'd6, 4'd11, 4'd1, 4'd8, 4'd8, 4'd0, 1'b0);
    step("R3 mispred", 4'd1, 4'd7, 4'd1, 4'd8, 4'd0, 4'd1, 1'b0);
    step("R3 taken",   4'd1, 4'd7, 4'd1, 4'd8, 4'd0, 4'd1, 1'b1);
    step("R4 retD",    4'd9, 4'd1, 4'd1, 4'd8, 4'd4, 4'd4, 1'b1);
    step("R4 retE",    4'd1, 4'd9, 4'd1, 4'd8, 4'd4, 4'd4, 1'b1);
    step("R4 retM",    4'd1, 4'd1, 4'd9, 4'd8, 4'd4, 4'd4, 1'b1);
    step("R5 lu+ret",  4'd9, 4'd5, 4'd1, 4'd4, 4'd4, 4'd8, 1'b1);
    step("R5 lu+retM", 4'd6, 4'd11, 4'd9, 4'd4, 4'd4, 4'd8, 1'b1);
    step("R6 mp+ret",  4'd9, 4'd7, 4'd1, 4'd8, 4'd4, 4'd8, 1'b0);
    step("R10 idle2",  4'd0, 4'd2, 4'd3, 4'd1, 4'd5, 4'd6, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ops [7] = '{4'd0, 4'd1, 4'd5, 4'd7, 4'd9, 4'd11, 4'd6};
      step("R1 R3 R4 R5 R6 R10 rand",
           ops[$urandom_range(0, 6)], ops[$urandom_range(0, 6)],
           ops[$urandom_range(0, 6)], 4'($urandom_range(0, 8)),
           4'($urandom_range(0, 8)), 4'($urandom_range(0, 8)),
           1'($urandom_range(0, 1)));
    end
    @(negedge clk);
    chk_regs("R8 regs");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule